// File: doc/BRIEF.md
# LCD Frame Tick Generator

This block produces the timing enables for a multiplexed segment LCD from one slow input clock. A power-of-two prescaler and a second divider stage sit in series, and the overall ratio is 2^PS × (16 + DIV). The block issues a one-cycle divided tick at that rate. A phase sequencer steps through the common lines of the panel. It marks the tick that begins each frame, and the number of phases per frame follows the selected multiplex duty.

Software writes new PS, DIV and duty values through a single-strobe write port. The values go into a pending stage first. They enter the active logic only at the tick that closes the period in progress, so no period is ever cut short. A sync-done flag drops on every write and comes back once a full divided period has run under the new values. The outputs are clock enables for downstream logic running on the same clock. They are not derived clocks.

Top module: `lcd_frame_tick_gen`

## Requirements
- R1: While `rst_ni` is low, and just after it is released, `tick_o` and `frame_o` are low, `phase_o` is 0 and `sync_done_o` is 1. Reset loads PS=0, DIV=0 and duty code 3 (four phases), so ticks come every 16 cycles.
- R2: `tick_o` is high for exactly one cycle every 2^PS × (16 + DIV) input cycles, with PS and DIV taken from the active settings.
- R3: With PS=4 and DIV=1 the tick period is 272 cycles (divide by 16, then by 17).
- R4: In the cycle after `cfg_we_i` is sampled high, `sync_done_o` is 0.
- R5: A write never shortens the period in progress. The tick that ends that period still comes at the old spacing, and the new PS, DIV and duty apply from that tick onward.
- R6: `sync_done_o` goes high together with the first tick that completes a full period under the new settings, and it rises at no other time.
- R7: The duty code `cfg_duty_i` selects the number of phases per frame: 0→1, 1→2, 2→3, 3→4, 4→8, and codes 5 to 7→1. `frame_o` pulses on every tick where `phase_o` returns to 0.
- R8: `phase_o` advances by one, modulo the phase count, on every tick, and holds its value between ticks.
- R9: The tick at which new settings take effect restarts the frame: on that tick `phase_o` is 0 and `frame_o` is high.
- R10: `frame_o` is high only in a cycle where `tick_o` is high and `phase_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock (the slow LCD source clock) |
| rst_ni | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Write strobe for the setting fields, one cycle per write |
| cfg_ps_i | input | 4 | Power-of-two prescale exponent |
| cfg_div_i | input | 4 | Second-stage addend; the stage divides by 16 + this value |
| cfg_duty_i | input | 3 | Duty code selecting the phases per frame |
| tick_o | output | 1 | One-cycle divided-clock enable |
| frame_o | output | 1 | One-cycle enable on the tick that starts a frame |
| phase_o | output | 3 | Index of the common line currently driven |
| sync_done_o | output | 1 | High once the written settings are in effect |

## Verification
The assertions assume that `cfg_we_i` is a single-cycle strobe and that reset lasts at least one clock edge. The minimum tick spacing assertion also relies on the fixed base of 16, which keeps ticks at least 16 cycles apart. The bench writes settings only at the falling clock edge, one strobe at a time, and each write follows an observed tick. This makes the expected old-period and new-period spacings exact. Every write is followed by a wait until `sync_done_o` returns before the next one, so the bench never depends on what happens when writes overlap.

// File: rtl/lcdt_pkg.sv
// Package: shared widths, the duty code type and the phase-count decode for
// the LCD frame tick generator. Assumes the duty field is three bits wide.
package lcdt_pkg;

    localparam int PS_W       = 4;   // prescale exponent field width
    localparam int DIV_W      = 4;   // second-stage addend field width
    localparam int DIV_BASE   = 16;  // fixed base of the second stage
    localparam int DUTY_W     = 3;   // duty code width
    localparam int MAX_PHASES = 8;   // largest phase count per frame
    localparam int PH_W       = $clog2(MAX_PHASES);

    typedef enum logic [DUTY_W-1:0] {
        DUTY_STATIC = 3'd0,
        DUTY_HALF   = 3'd1,
        DUTY_THIRD  = 3'd2,
        DUTY_QUART  = 3'd3,
        DUTY_EIGHTH = 3'd4
    } duty_e;

    localparam logic [DUTY_W-1:0] DUTY_RESET = DUTY_QUART;

    // Index of the last phase in a frame for a duty code (phases - 1).
    function automatic logic [PH_W-1:0] last_phase(input logic [DUTY_W-1:0] code);
        logic [PH_W-1:0] r;
        case (code)
            DUTY_HALF:   r = PH_W'(1);
            DUTY_THIRD:  r = PH_W'(2);
            DUTY_QUART:  r = PH_W'(3);
            DUTY_EIGHTH: r = PH_W'(7);
            default:     r = PH_W'(0);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lcdt_cfg_stage.sv
// Setting stage: holds written settings as pending and moves them into the
// active set only on a divided tick, where both counters wrap to zero, so
// no period is truncated. Tracks the sync-done flag.
// Assumes: we_i is a one-cycle strobe; tick_raw_i comes from the divider
// running on the active settings.
module lcdt_cfg_stage
    import lcdt_pkg::*;
#(
    parameter int PS_WIDTH   = PS_W,
    parameter int DIV_WIDTH  = DIV_W,
    parameter int DUTY_WIDTH = DUTY_W,
    parameter logic [DUTY_WIDTH-1:0] DUTY_INIT = DUTY_RESET
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  we_i,
    input  logic [PS_WIDTH-1:0]   ps_i,
    input  logic [DIV_WIDTH-1:0]  div_i,
    input  logic [DUTY_WIDTH-1:0] duty_i,
    input  logic                  tick_raw_i,
    output logic [PS_WIDTH-1:0]   act_ps_o,
    output logic [DIV_WIDTH-1:0]  act_div_o,
    output logic [DUTY_WIDTH-1:0] act_duty_o,
    output logic                  load_o,
    output logic                  sync_done_o
);

    logic [PS_WIDTH-1:0]   pend_ps_q;
    logic [DIV_WIDTH-1:0]  pend_div_q;
    logic [DUTY_WIDTH-1:0] pend_duty_q;
    logic                  pend_q;   // pending set not yet active
    logic                  armed_q;  // new set active, first full period running

    // Transfer happens on a tick while a set is pending and no write collides.
    assign load_o = tick_raw_i && pend_q && !we_i;

    // Capture written values into the pending registers.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pend_ps_q   <= '0;
            pend_div_q  <= '0;
            pend_duty_q <= DUTY_INIT;
        end else if (we_i) begin
            pend_ps_q   <= ps_i;
            pend_div_q  <= div_i;
            pend_duty_q <= duty_i;
        end
    end

    // Copy the pending set into the active set at a tick boundary.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            act_ps_o   <= '0;
            act_div_o  <= '0;
            act_duty_o <= DUTY_INIT;
        end else if (load_o) begin
            act_ps_o   <= pend_ps_q;
            act_div_o  <= pend_div_q;
            act_duty_o <= pend_duty_q;
        end
    end

    // Sequence pending -> armed -> synced; a write restarts the sequence.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pend_q      <= 1'b0;
            armed_q     <= 1'b0;
            sync_done_o <= 1'b1;
        end else if (we_i) begin
            pend_q      <= 1'b1;
            armed_q     <= 1'b0;
            sync_done_o <= 1'b0;
        end else if (load_o) begin
            pend_q      <= 1'b0;
            armed_q     <= 1'b1;
        end else if (tick_raw_i && armed_q) begin
            armed_q     <= 1'b0;
            sync_done_o <= 1'b1;
        end
    end

endmodule

// File: rtl/lcdt_prescaler.sv
// Power-of-two prescaler: emits a one-cycle pulse every 2^ps_i input cycles.
// Assumes ps_i changes only when the counter has just wrapped.
module lcdt_prescaler #(
    parameter int PS_WIDTH = 4,
    localparam int CNT_W   = (2 ** PS_WIDTH) - 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [PS_WIDTH-1:0] ps_i,
    output logic                pulse_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Terminal count 2^ps - 1; the shift wraps to zero at the top exponent.
    always_comb begin
        limit   = (CNT_W'(1) << ps_i) - CNT_W'(1);
        pulse_o = (cnt_q == limit);
    end

    // Free-running count that wraps at the terminal value.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      cnt_q <= '0;
        else if (pulse_o) cnt_q <= '0;
        else              cnt_q <= cnt_q + CNT_W'(1);
    end

endmodule

// File: rtl/lcdt_divider.sv
// Second divider stage: counts BASE + div_i prescaler pulses and flags the
// last one as the raw divided tick.
// Assumes div_i changes only on the cycle of a raw tick.
module lcdt_divider #(
    parameter int DIV_WIDTH = 4,
    parameter int BASE      = 16,
    localparam int CNT_W    = $clog2(BASE + (2 ** DIV_WIDTH))
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 step_i,
    input  logic [DIV_WIDTH-1:0] div_i,
    output logic                 tick_raw_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Terminal count BASE + div - 1, and the tick on the matching step.
    always_comb begin
        limit      = CNT_W'(BASE - 1) + CNT_W'(div_i);
        tick_raw_o = step_i && (cnt_q == limit);
    end

    // Advance once per prescaler pulse and wrap at the terminal count.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)         cnt_q <= '0;
        else if (tick_raw_o) cnt_q <= '0;
        else if (step_i)     cnt_q <= cnt_q + CNT_W'(1);
    end

endmodule

// File: rtl/lcdt_phase_seq.sv
// Phase sequencer: registers the divided tick, steps the common-line index
// on each tick and flags the tick that starts a frame. A settings load
// restarts the frame at phase 0.
// Assumes duty_i changes only together with load_i.
module lcdt_phase_seq
    import lcdt_pkg::*;
#(
    parameter int DUTY_WIDTH = DUTY_W,
    parameter int PHASE_W    = PH_W
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  tick_raw_i,
    input  logic                  load_i,
    input  logic [DUTY_WIDTH-1:0] duty_i,
    output logic                  tick_o,
    output logic                  frame_o,
    output logic [PHASE_W-1:0]    phase_o
);

    logic [PHASE_W-1:0] last;
    logic               wrap;

    // Last index for the current duty and the wrap condition.
    always_comb begin
        last = PHASE_W'(last_phase(duty_i));
        wrap = load_i || (phase_o >= last);
    end

    // Register the tick and its frame marker together with the new index.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            tick_o  <= 1'b0;
            frame_o <= 1'b0;
            phase_o <= '0;
        end else begin
            tick_o  <= tick_raw_i;
            frame_o <= tick_raw_i && wrap;
            if (tick_raw_i) phase_o <= wrap ? '0 : phase_o + PHASE_W'(1);
        end
    end

endmodule

// File: rtl/lcd_frame_tick_gen.sv
// Top: LCD frame tick generator. Prescaler (2^PS) feeds the second stage
// (16 + DIV); the raw tick drives the phase sequencer and the setting
// stage. All outputs are registered single-clock enables.
// Assumes one clock domain and a one-cycle write strobe.
module lcd_frame_tick_gen
    import lcdt_pkg::*;
#(
    parameter int PS_WIDTH   = PS_W,
    parameter int DIV_WIDTH  = DIV_W,
    parameter int BASE       = DIV_BASE,
    parameter int DUTY_WIDTH = DUTY_W,
    parameter int PHASE_W    = PH_W
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  cfg_we_i,
    input  logic [PS_WIDTH-1:0]   cfg_ps_i,
    input  logic [DIV_WIDTH-1:0]  cfg_div_i,
    input  logic [DUTY_WIDTH-1:0] cfg_duty_i,
    output logic                  tick_o,
    output logic                  frame_o,
    output logic [PHASE_W-1:0]    phase_o,
    output logic                  sync_done_o
);

    logic [PS_WIDTH-1:0]   act_ps;
    logic [DIV_WIDTH-1:0]  act_div;
    logic [DUTY_WIDTH-1:0] act_duty;
    logic                  load;
    logic                  pre_pulse;
    logic                  tick_raw;

    lcdt_cfg_stage #(
        .PS_WIDTH   (PS_WIDTH),
        .DIV_WIDTH  (DIV_WIDTH),
        .DUTY_WIDTH (DUTY_WIDTH),
        .DUTY_INIT  (DUTY_WIDTH'(DUTY_RESET))
    ) u_cfg (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .we_i        (cfg_we_i),
        .ps_i        (cfg_ps_i),
        .div_i       (cfg_div_i),
        .duty_i      (cfg_duty_i),
        .tick_raw_i  (tick_raw),
        .act_ps_o    (act_ps),
        .act_div_o   (act_div),
        .act_duty_o  (act_duty),
        .load_o      (load),
        .sync_done_o (sync_done_o)
    );

    lcdt_prescaler #(
        .PS_WIDTH (PS_WIDTH)
    ) u_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .ps_i    (act_ps),
        .pulse_o (pre_pulse)
    );

    lcdt_divider #(
        .DIV_WIDTH (DIV_WIDTH),
        .BASE      (BASE)
    ) u_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .step_i     (pre_pulse),
        .div_i      (act_div),
        .tick_raw_o (tick_raw)
    );

    lcdt_phase_seq #(
        .DUTY_WIDTH (DUTY_WIDTH),
        .PHASE_W    (PHASE_W)
    ) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_raw_i (tick_raw),
        .load_i     (load),
        .duty_i     (act_duty),
        .tick_o     (tick_o),
        .frame_o    (frame_o),
        .phase_o    (phase_o)
    );

endmodule

// File: rtl/lcdt_checker.sv
// Checker for the LCD frame tick generator, bound to the top module.
// Assumes a one-cycle write strobe and the fixed base of 16.
module lcdt_checker #(
    parameter int PHASE_W = 3,
    parameter int MIN_GAP = 16
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               cfg_we_i,
    input logic               tick_o,
    input logic               frame_o,
    input logic [PHASE_W-1:0] phase_o,
    input logic               sync_done_o
);

    logic [15:0] gap_q;

    // Cycles since the last tick, saturating.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || tick_o) gap_q <= '0;
        else if (gap_q != 16'hFFFF) gap_q <= gap_q + 16'd1;
    end

    // R2
    tick_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);

    // R5
    tick_min_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> (gap_q >= 16'(MIN_GAP - 1)));

    // R4
    write_clears_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_we_i |=> !sync_done_o);

    // R6
    sync_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sync_done_o) |-> tick_o);

    // R8
    phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_o |-> $stable(phase_o));

    // R10
    frame_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_o |-> (tick_o && phase_o == '0));

endmodule

bind lcd_frame_tick_gen lcdt_checker #(
    .PHASE_W (PHASE_W),
    .MIN_GAP (BASE)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .tick_o      (tick_o),
    .frame_o     (frame_o),
    .phase_o     (phase_o),
    .sync_done_o (sync_done_o)
);

// File: tb/lcd_frame_tick_gen_test.sv
`timescale 1ns/1ps
module lcd_frame_tick_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [3:0] ps = '0;
    logic [3:0] dv = '0;
    logic [2:0] duty = '0;
    logic       tick, frame, sync;
    logic [2:0] phase;

    int checks = 0;
    int errors = 0;
    int r10_bad = 0;

    always #2 clk = ~clk;

    lcd_frame_tick_gen uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .cfg_we_i    (we),
        .cfg_ps_i    (ps),
        .cfg_div_i   (dv),
        .cfg_duty_i  (duty),
        .tick_o      (tick),
        .frame_o     (frame),
        .phase_o     (phase),
        .sync_done_o (sync)
    );

    // Observe the frame marker against the tick on every falling edge.
    always @(negedge clk) if (rst_n && frame && (!tick || phase != 3'd0)) r10_bad++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count falling edges until one shows tick high.
    task automatic next_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick && n < 40000);
    endtask

    function automatic int phases_of(input logic [2:0] c);
        case (c)
            3'd1: return 2;
            3'd2: return 3;
            3'd3: return 4;
            3'd4: return 8;
            default: return 1;
        endcase
    endfunction

    // Write settings just after a tick; wait until they are synced.
    task automatic apply_cfg(input logic [3:0] p, input logic [3:0] d, input logic [2:0] c);
        int n;
        next_tick(n);
        ps = p; dv = d; duty = c; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        for (int k = 0; k < 3 && !sync; k++) next_tick(n);
    endtask

    task automatic t_reset;
        int n;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 tick in reset", int'(tick), 0);
        check("R1 frame in reset", int'(frame), 0);
        check("R1 phase in reset", int'(phase), 0);
        check("R1 sync in reset", int'(sync), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 tick after release", int'(tick), 0);
        next_tick(n);
        next_tick(n);
        check("R1 default period", n, 16);
        next_tick(n);
        check("R2 default period repeat", n, 16);
        @(negedge clk);
        check("R2 tick one cycle wide", int'(tick), 0);
    endtask

    task automatic t_switch;
        int n;
        next_tick(n);
        ps = 4'd1; dv = 4'd2; duty = 3'd3; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        check("R4 sync cleared after write", int'(sync), 0);
        next_tick(n);
        check("R5 old period kept", n + 1, 16);
        check("R6 sync low on load tick", int'(sync), 0);
        check("R9 load tick phase", int'(phase), 0);
        check("R9 load tick frame", int'(frame), 1);
        next_tick(n);
        check("R5 new period applied", n, 36);
        check("R6 sync high on first full period", int'(sync), 1);
        check("R8 phase after load", int'(phase), 1);
        next_tick(n);
        check("R2 period 2*18", n, 36);
    endtask

    task automatic t_ratio(input logic [3:0] p, input logic [3:0] d, input string req);
        int n;
        apply_cfg(p, d, 3'd3);
        next_tick(n);
        check(req, n, (1 << p) * (16 + d));
    endtask

    task automatic t_duty(input logic [2:0] c);
        int n, np;
        np = phases_of(c);
        apply_cfg(4'd0, 4'd0, c);
        do next_tick(n); while (!frame);
        for (int k = 1; k <= np; k++) begin
            next_tick(n);
            check("R8 phase step", int'(phase), k % np);
            check("R7 frame marker", int'(frame), (k == np) ? 1 : 0);
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_switch();
        t_ratio(4'd4, 4'd1, "R3 PS4 DIV1 period");
        t_ratio(4'd0, 4'd15, "R2 PS0 DIV15 period");
        t_ratio(4'd2, 4'd0, "R2 PS2 DIV0 period");
        t_ratio(4'd3, 4'd7, "R2 PS3 DIV7 period");
        t_duty(3'd0);
        t_duty(3'd1);
        t_duty(3'd2);
        t_duty(3'd4);
        t_duty(3'd6);
        check("R10 frame only on tick at phase 0", r10_bad, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule